// File: doc/BRIEF.md
# Branch Scan and Folding Unit

This block sits beside an instruction queue and acts as the branch-execution front end. Every cycle it looks at a fixed window of the oldest queue slots and picks the oldest branch that has not executed yet. It then resolves that branch from a taken flag and target address that the surrounding logic supplies. It decides whether the branch disappears from the queue (folding) or must still go to dispatch, and it drives a fetch redirect together with the length of the fetch bubble that the redirect costs.

Direct branches that are taken probe a small direct-mapped target cache, indexed by the branch's own address. On a hit the cache hands four target instructions to fetch on the next cycle, and the bubble shrinks to one cycle. Indirect branches never probe it. When a taken direct branch misses, the surrounding logic writes the target instructions into the cache through a fill port, so the next execution of that branch can hit.

The queue owner applies the results at the next clock edge. It marks the selected slot executed, or deletes it when the fold strobe is high.

Top module: `brfold_unit`

## Requirements
- R1: Slot 0 is the oldest. The selected slot is the lowest-index slot in the window whose valid and branch flags are set and whose executed flag is clear. `br_sel` reports whether such a slot exists and `br_idx` gives its index. When none exists, `br_sel`, `fold_rm`, `disp_need` and `redir_en` are all 0 and `bubble_cyc` is 0.
- R2: A selected branch that is taken and writes neither the link register nor the count register raises `fold_rm` with `disp_need` low, in the same cycle.
- R3: A selected branch that is not taken raises `disp_need`, keeps `fold_rm` and `redir_en` low, and gives `bubble_cyc` = 0. This holds even when the branch is foldable.
- R4: A selected taken branch that writes the link or count register raises `redir_en` and `disp_need`, and keeps `fold_rm` low.
- R5: A selected taken direct branch whose address hits the target cache gives `bubble_cyc` = 1. Its redirect address is the supplied target plus LINE_INSNS*INSN_W/8 (16 bytes with the defaults).
- R6: A selected taken branch that is indirect, or direct and missing the cache, gives `bubble_cyc` = 2 and a redirect address equal to the supplied target.
- R7: An indirect branch never probes the cache: `tc_valid` is 0 in the following cycle, even when the cache holds a line for that address.
- R8: After a hit, `tc_valid` is 1 in the next cycle and `tc_insns` carries the filled line, with instruction 0 in the low INSN_W bits. After any cycle without a hit, `tc_valid` is 0.
- R9: The cache is direct-mapped. It is indexed by address bits [IDX_W+1:2] and tagged with the bits above them. A fill replaces the line at its index, so a later fill to the same index with a different tag evicts the older line. A lookup in the same cycle as a fill sees the contents from before the fill.
- R10: Reset empties the cache and clears `tc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | SCAN_W | Slot holds an instruction |
| q_is_br | input | SCAN_W | Slot holds a branch |
| q_indir | input | SCAN_W | Branch goes through the link or count register |
| q_wr_lr | input | SCAN_W | Branch writes the link register |
| q_wr_ctr | input | SCAN_W | Branch writes the count register |
| q_done | input | SCAN_W | Branch already executed |
| q_addr | input | SCAN_W*ADDR_W | Instruction address per slot, slot i at bits [i*ADDR_W +: ADDR_W] |
| rs_taken | input | 1 | Resolution of the selected branch |
| rs_target | input | ADDR_W | Target address of the selected branch |
| fill_en | input | 1 | Write a line into the target cache |
| fill_addr | input | ADDR_W | Branch address that the line belongs to |
| fill_insns | input | LINE_INSNS*INSN_W | Target instructions to store |
| br_sel | output | 1 | A branch executes this cycle |
| br_idx | output | $clog2(SCAN_W) | Slot of the executing branch |
| fold_rm | output | 1 | Delete the selected slot from the queue |
| disp_need | output | 1 | Keep the slot, marked executed, for dispatch |
| redir_en | output | 1 | Redirect fetch |
| redir_addr | output | ADDR_W | Fetch redirect address |
| bubble_cyc | output | 2 | Fetch bubble length in cycles (0, 1 or 2) |
| tc_valid | output | 1 | Target-cache instructions are valid this cycle |
| tc_insns | output | LINE_INSNS*INSN_W | Instructions from the target cache |

## Verification
The bench builds the unit with a full eight-slot window and reduces the target cache to four entries. Queue addresses come from a pool of sixteen words, so four tags compete for each cache index. That makes hits, cold misses and conflict evictions all frequent under random stimulus, and it lets directed cases evict a line with a single fill. Because every direct miss is followed by a fill, repeat executions of a branch reach the one-cycle-bubble path again and again, alongside the fold, dispatch and indirect paths.

// File: rtl/brfold_pkg.sv
package brfold_pkg;

    typedef enum logic [1:0] {
        BUB_NONE = 2'd0,
        BUB_ONE  = 2'd1,
        BUB_TWO  = 2'd2
    } bubble_e;

    // Per-slot flags; bit order matters for the concatenation in the top.
    typedef struct packed {
        logic valid;
        logic is_br;
        logic indir;
        logic wr_lr;
        logic wr_ctr;
        logic done;
    } qent_t;

    typedef struct packed {
        logic fold;
        logic disp;
        logic redir;
        logic lookup;
    } act_t;

    function automatic logic eligible(qent_t e);
        return e.valid && e.is_br && !e.done;
    endfunction

    function automatic logic foldable(qent_t e);
        return !(e.wr_lr || e.wr_ctr);
    endfunction

    function automatic bubble_e bubble_len(logic taken, logic indir, logic hit);
        if (!taken)
            return BUB_NONE;
        else if (!indir && hit)
            return BUB_ONE;
        else
            return BUB_TWO;
    endfunction

endpackage

// File: rtl/brfold_scan.sv
module brfold_scan
    import brfold_pkg::*;
#(
    parameter int SCAN_W = 8,
    localparam int IDX_W = $clog2(SCAN_W)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  qent_t [SCAN_W-1:0]    ents,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);

    logic [SCAN_W-1:0] elig;

    for (genvar g = 0; g < SCAN_W; g++) begin : g_elig
        assign elig[g] = eligible(ents[g]);
    end

    always_comb begin
        found = |elig;
        idx   = '0;
        for (int i = SCAN_W - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end

    // R1
    pick_elig_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (ents[idx].valid && ents[idx].is_br && !ents[idx].done));

    // R1
    pick_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        (found && idx != '0) |-> !(ents[0].valid && ents[0].is_br && !ents[0].done));

endmodule

// File: rtl/brfold_resolve.sv
module brfold_resolve
    import brfold_pkg::*;
(
    input  logic    found,
    input  qent_t   ent,
    input  logic    taken,
    input  logic    hit,
    output act_t    act,
    output bubble_e bub
);

    always_comb begin
        act.redir  = found && taken;
        act.lookup = found && taken && !ent.indir;
        act.fold   = found && taken && foldable(ent);
        act.disp   = found && !(taken && foldable(ent));
    end

    always_comb begin
        bub = found ? bubble_len(taken, ent.indir, hit) : BUB_NONE;
    end

endmodule

// File: rtl/brfold_btc.sv
module brfold_btc #(
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int DEPTH      = 16,
    parameter int LINE_INSNS = 4,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int TAG_W     = ADDR_W - IDX_W - 2,
    localparam int LINE_W    = LINE_INSNS * INSN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line,
    output logic              hit,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_line
);

    logic [DEPTH-1:0]  vld;
    logic [TAG_W-1:0]  tags  [DEPTH];
    logic [LINE_W-1:0] lines [DEPTH];

    logic [IDX_W-1:0] lk_idx, fi_idx;
    logic [TAG_W-1:0] lk_tag, fi_tag;
    logic             unused_lo;

    assign lk_idx    = lk_addr[IDX_W+1:2];
    assign lk_tag    = lk_addr[ADDR_W-1:IDX_W+2];
    assign fi_idx    = fill_addr[IDX_W+1:2];
    assign fi_tag    = fill_addr[ADDR_W-1:IDX_W+2];
    assign unused_lo = ^{lk_addr[1:0], fill_addr[1:0]};

    assign hit = lk_en && vld[lk_idx] && (tags[lk_idx] == lk_tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld       <= '0;
            out_valid <= 1'b0;
            out_line  <= '0;
        end else begin
            out_valid <= hit;
            if (hit) out_line <= lines[lk_idx];
            if (fill_en) vld[fi_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && fill_en) begin
            tags[fi_idx]  <= fi_tag;
            lines[fi_idx] <= fill_line;
        end
    end

    // R8
    out_after_probe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(lk_en));

    // R9
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_en && !$past(rst) && $past(fill_en) && $past(fill_addr[ADDR_W-1:2]) == lk_addr[ADDR_W-1:2]) |-> hit);

endmodule

// File: rtl/brfold_unit.sv
module brfold_unit
    import brfold_pkg::*;
#(
    parameter int SCAN_W     = 8,
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int LINE_INSNS = 4,
    parameter int BTC_DEPTH  = 16,
    localparam int IDX_W     = $clog2(SCAN_W),
    localparam int LINE_W    = LINE_INSNS * INSN_W,
    localparam int ADV_BYTES = LINE_INSNS * INSN_W / 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SCAN_W-1:0]        q_valid,
    input  logic [SCAN_W-1:0]        q_is_br,
    input  logic [SCAN_W-1:0]        q_indir,
    input  logic [SCAN_W-1:0]        q_wr_lr,
    input  logic [SCAN_W-1:0]        q_wr_ctr,
    input  logic [SCAN_W-1:0]        q_done,
    input  logic [SCAN_W*ADDR_W-1:0] q_addr,
    input  logic                     rs_taken,
    input  logic [ADDR_W-1:0]        rs_target,
    input  logic                     fill_en,
    input  logic [ADDR_W-1:0]        fill_addr,
    input  logic [LINE_W-1:0]        fill_insns,
    output logic                     br_sel,
    output logic [IDX_W-1:0]         br_idx,
    output logic                     fold_rm,
    output logic                     disp_need,
    output logic                     redir_en,
    output logic [ADDR_W-1:0]        redir_addr,
    output logic [1:0]               bubble_cyc,
    output logic                     tc_valid,
    output logic [LINE_W-1:0]        tc_insns
);

    qent_t [SCAN_W-1:0] ents;
    qent_t              sel_ent;
    logic [ADDR_W-1:0]  sel_addr;
    act_t               act;
    bubble_e            bub;
    logic               hit;

    for (genvar g = 0; g < SCAN_W; g++) begin : g_ent
        assign ents[g] = {q_valid[g], q_is_br[g], q_indir[g],
                          q_wr_lr[g], q_wr_ctr[g], q_done[g]};
    end

    brfold_scan #(.SCAN_W(SCAN_W)) u_scan (
        .clk   (clk),
        .rst   (rst),
        .ents  (ents),
        .found (br_sel),
        .idx   (br_idx)
    );

    assign sel_ent  = ents[br_idx];
    assign sel_addr = q_addr[br_idx*ADDR_W +: ADDR_W];

    brfold_resolve u_res (
        .found (br_sel),
        .ent   (sel_ent),
        .taken (rs_taken),
        .hit   (hit),
        .act   (act),
        .bub   (bub)
    );

    brfold_btc #(
        .ADDR_W     (ADDR_W),
        .INSN_W     (INSN_W),
        .DEPTH      (BTC_DEPTH),
        .LINE_INSNS (LINE_INSNS)
    ) u_btc (
        .clk       (clk),
        .rst       (rst),
        .lk_en     (act.lookup),
        .lk_addr   (sel_addr),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_line (fill_insns),
        .hit       (hit),
        .out_valid (tc_valid),
        .out_line  (tc_insns)
    );

    assign fold_rm    = act.fold;
    assign disp_need  = act.disp;
    assign redir_en   = act.redir;
    assign bubble_cyc = bub;
    assign redir_addr = hit ? rs_target + ADDR_W'(ADV_BYTES) : rs_target;

    // R5
    short_bubble_feeds_chk: assert property (@(posedge clk) disable iff (rst)
        (bubble_cyc == BUB_ONE) |=> tc_valid);

    // R7
    tc_direct_only_chk: assert property (@(posedge clk) disable iff (rst)
        tc_valid |-> $past(br_sel && rs_taken && !q_indir[br_idx]));

    // R6
    long_bubble_redir_chk: assert property (@(posedge clk) disable iff (rst)
        (bubble_cyc == BUB_TWO) |-> (redir_en && redir_addr == rs_target));

    // R2
    fold_excl_chk: assert property (@(posedge clk) disable iff (rst)
        fold_rm |-> (redir_en && !q_wr_lr[br_idx] && !q_wr_ctr[br_idx]));

endmodule

// File: tb/tb_brfold_unit.sv
module tb_brfold_unit;

    localparam int SW = 8;
    localparam int AW = 32;
    localparam int LW = 128;

    logic          clk = 1'b0;
    logic          rst;
    logic [SW-1:0] q_valid, q_is_br, q_indir, q_wr_lr, q_wr_ctr, q_done;
    logic [SW*AW-1:0] q_addr;
    logic          rs_taken;
    logic [AW-1:0] rs_target;
    logic          fill_en;
    logic [AW-1:0] fill_addr;
    logic [LW-1:0] fill_insns;
    logic          br_sel, fold_rm, disp_need, redir_en, tc_valid;
    logic [2:0]    br_idx;
    logic [AW-1:0] redir_addr;
    logic [1:0]    bubble_cyc;
    logic [LW-1:0] tc_insns;

    brfold_unit #(.BTC_DEPTH(4)) dut (
        .clk(clk), .rst(rst),
        .q_valid(q_valid), .q_is_br(q_is_br), .q_indir(q_indir),
        .q_wr_lr(q_wr_lr), .q_wr_ctr(q_wr_ctr), .q_done(q_done),
        .q_addr(q_addr), .rs_taken(rs_taken), .rs_target(rs_target),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_insns(fill_insns),
        .br_sel(br_sel), .br_idx(br_idx), .fold_rm(fold_rm),
        .disp_need(disp_need), .redir_en(redir_en), .redir_addr(redir_addr),
        .bubble_cyc(bubble_cyc), .tc_valid(tc_valid), .tc_insns(tc_insns)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference cache model (4 entries, index addr[3:2])
    bit            m_v [4];
    logic [27:0]   m_tag [4];
    logic [LW-1:0] m_line [4];
    bit            exp_tcv;
    logic [LW-1:0] exp_line;
    string         tc_req;
    bit            pend;
    logic [AW-1:0] pend_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_q();
        q_valid = '0; q_is_br = '0; q_indir = '0; q_wr_lr = '0;
        q_wr_ctr = '0; q_done = '0; q_addr = '0;
        rs_taken = 0; rs_target = '0; fill_en = 0; fill_addr = '0; fill_insns = '0;
    endtask

    task automatic put(input int i, input bit br, input bit ind, input bit lr,
                       input bit ct, input bit dn, input logic [AW-1:0] a);
        q_valid[i] = 1; q_is_br[i] = br; q_indir[i] = ind; q_wr_lr[i] = lr;
        q_wr_ctr[i] = ct; q_done[i] = dn; q_addr[i*AW +: AW] = a;
    endtask

    function automatic logic [LW-1:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Called at posedge+1 with inputs driven; checks at posedge+4.
    task automatic run_cycle();
        int ei = 0;
        bit ef = 0, tk, fl, ind, hit, conflict;
        int mi;
        logic [AW-1:0] ba, rexp;
        logic [1:0] bexp;
        string breq;
        for (int i = SW - 1; i >= 0; i--)
            if (q_valid[i] && q_is_br[i] && !q_done[i]) begin ef = 1; ei = i; end
        tk  = rs_taken;
        ba  = q_addr[ei*AW +: AW];
        ind = q_indir[ei];
        fl  = !(q_wr_lr[ei] || q_wr_ctr[ei]);
        mi  = int'(ba[3:2]);
        hit = ef && tk && !ind && m_v[mi] && m_tag[mi] == ba[31:4];
        conflict = ef && tk && !ind && m_v[mi] && !hit;
        #3;
        chk(br_sel == ef, "R1", "br_sel", LW'(br_sel), LW'(ef));
        if (ef) chk(br_idx == 3'(ei), "R1", "br_idx", LW'(br_idx), LW'(ei));
        chk(fold_rm == (ef && tk && fl), "R2", "fold_rm", LW'(fold_rm), LW'(ef && tk && fl));
        chk(disp_need == (ef && !(tk && fl)), tk ? "R4" : "R3", "disp_need",
            LW'(disp_need), LW'(ef && !(tk && fl)));
        chk(redir_en == (ef && tk), tk ? "R4" : "R3", "redir_en", LW'(redir_en), LW'(ef && tk));
        bexp = (!ef || !tk) ? 2'd0 : (hit ? 2'd1 : 2'd2);
        breq = (!ef) ? "R1" : (!tk) ? "R3" : hit ? "R5" : conflict ? "R9" : "R6";
        chk(bubble_cyc == bexp, breq, "bubble_cyc", LW'(bubble_cyc), LW'(bexp));
        if (ef && tk) begin
            rexp = hit ? rs_target + 32'd16 : rs_target;
            chk(redir_addr == rexp, hit ? "R5" : "R6", "redir_addr", LW'(redir_addr), LW'(rexp));
        end
        chk(tc_valid == exp_tcv, tc_req, "tc_valid", LW'(tc_valid), LW'(exp_tcv));
        if (exp_tcv) chk(tc_insns == exp_line, "R8", "tc_insns", tc_insns, exp_line);
        // advance model to the coming edge
        exp_tcv = hit;
        if (hit) exp_line = m_line[mi];
        tc_req = (ef && tk && ind) ? "R7" : "R8";
        if (fill_en) begin
            m_v[fill_addr[3:2]]    = 1;
            m_tag[fill_addr[3:2]]  = fill_addr[31:4];
            m_line[fill_addr[3:2]] = fill_insns;
        end
        pend = ef && tk && !ind && !hit;
        pend_addr = ba;
    endtask

    task automatic do_reset();
        rst = 1;
        clear_q();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        for (int i = 0; i < 4; i++) m_v[i] = 0;
        exp_tcv = 0;
        tc_req = "R10";
        pend = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] la;
        void'($urandom(32'd4242));
        do_reset();
        // R10 / R1: empty queue right after reset
        @(posedge clk); #1 clear_q(); run_cycle();
        // R1: oldest eligible, then next after marking executed
        @(posedge clk); #1 clear_q();
        put(0, 0, 0, 0, 0, 0, 32'h100); put(1, 1, 0, 1, 0, 0, 32'h104);
        put(2, 1, 0, 0, 0, 1, 32'h108); put(3, 1, 0, 0, 0, 0, 32'h10C);
        run_cycle();
        @(posedge clk); #1 q_done[1] = 1; run_cycle();
        // R2 / R6: taken foldable indirect
        @(posedge clk); #1 clear_q(); put(0, 1, 1, 0, 0, 0, 32'h2000);
        rs_taken = 1; rs_target = 32'h8000; run_cycle();
        // R4 / R6: taken direct, writes link, cold miss
        @(posedge clk); #1 clear_q(); put(0, 1, 0, 1, 0, 0, 32'h2000);
        rs_taken = 1; rs_target = 32'h9000; run_cycle();
        // fill the line for 0x2000
        la = 128'h44444444_33333333_22222222_11111111;
        @(posedge clk); #1 clear_q(); fill_en = 1; fill_addr = 32'h2000; fill_insns = la; run_cycle();
        // R5 / R8: hit, then line delivered next cycle
        @(posedge clk); #1 clear_q(); put(2, 1, 0, 0, 0, 0, 32'h2000);
        rs_taken = 1; rs_target = 32'h9000; run_cycle();
        @(posedge clk); #1 clear_q(); run_cycle();
        // R7: indirect at a cached address
        @(posedge clk); #1 clear_q(); put(0, 1, 1, 0, 1, 0, 32'h2000);
        rs_taken = 1; rs_target = 32'hA000; run_cycle();
        @(posedge clk); #1 clear_q(); run_cycle();
        // R9: evict with same index, other tag, then miss
        @(posedge clk); #1 clear_q(); fill_en = 1; fill_addr = 32'h2010; fill_insns = rnd_line(); run_cycle();
        @(posedge clk); #1 clear_q(); put(0, 1, 0, 0, 0, 0, 32'h2000);
        rs_taken = 1; rs_target = 32'hB000; run_cycle();
        // R3: not-taken foldable branch still dispatched
        @(posedge clk); #1 clear_q(); put(0, 1, 0, 0, 0, 0, 32'h2010);
        rs_taken = 0; rs_target = 32'hC000; run_cycle();
        // R10: reset clears the cache
        @(posedge clk); #1 clear_q(); fill_en = 1; fill_addr = 32'h3000; fill_insns = rnd_line(); run_cycle();
        do_reset();
        @(posedge clk); #1 clear_q(); put(0, 1, 0, 0, 0, 0, 32'h3000);
        rs_taken = 1; rs_target = 32'hD000; run_cycle();
        // constrained random
        for (int n = 0; n < 3000; n++) begin
            bit pf = pend;
            logic [AW-1:0] pa = pend_addr;
            @(posedge clk); #1 clear_q();
            for (int i = 0; i < SW; i++) begin
                if ($urandom % 4 != 0)
                    put(i, $urandom % 3 == 0, $urandom % 3 == 0, $urandom % 4 == 0,
                        $urandom % 5 == 0, $urandom % 3 == 0, 32'h1000 + ($urandom % 16) * 4);
            end
            rs_taken  = $urandom % 2;
            rs_target = $urandom & 32'hFFFF_FFFC;
            if (pf) begin
                fill_en = 1; fill_addr = pa;
            end else begin
                fill_en = ($urandom % 8 == 0);
                fill_addr = 32'h1000 + ($urandom % 16) * 4;
            end
            fill_insns = rnd_line();
            run_cycle();
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule